// File: doc/BRIEF.md
# Flash Status Polling Verifier

This block runs on the host side of a flash interface once a program or erase command has been issued. It reads the device's status byte over and over at an address the surrounding logic has already chosen, and decides whether the operation finished or failed. The decision uses two bits of that byte. The top bit is compared against the value the operation should leave behind. For a program this is the top bit of the byte being written; for an erase it is always 1. The bit two places below is the device's own error flag.

A raised error flag does not end the operation at once. The top bit can flip in the same read that shows the flag, so the block makes one more read and compares the top bit again. When a match is seen, the block trusts only the top bit of that byte, because the lower bits may still lag behind. It therefore makes one final confirming read and reports that byte as the verified data. A poll budget set by a parameter ends the operation with a failure if the device never settles.

The read side is a plain request/valid handshake. The request is held high until the responder returns a byte with a one-cycle valid strobe.

Top module: `flash_poll_verifier`

## Requirements
- R1: After reset, rd_req_o, done_o, pass_o and fail_o are 0 and final_data_o is 0.
- R2: A start_i pulse while idle is accepted. It clears pass_o and fail_o and raises rd_req_o on the next cycle. rd_req_o then stays high until the operation concludes.
- R3: When a status read (rd_vld_i high) has bit 7 equal to the expected bit, the block makes exactly one more read. It then ends with pass_o = 1, and final_data_o equals the byte from that extra read.
- R4: When a status read has bit 7 different from the expected bit and bit 5 = 0, the block reads again and repeats the comparison.
- R5: When a status read has bit 7 mismatching and bit 5 = 1, the block makes one recheck read. If bit 7 matches on the recheck, the flow continues as in R3. If it mismatches, the block ends with fail_o = 1, and final_data_o equals the recheck byte.
- R6: With erase_i = 1 at start, the expected bit 7 is 1 whatever exp_data_i holds. With erase_i = 0, it is exp_data_i[7], sampled when start is accepted.
- R7: After MAX_POLLS consecutive plain polls (bit 7 mismatching, bit 5 = 0), the block ends with fail_o = 1, and final_data_o equals the last polled byte.
- R8: A start_i pulse while an operation is in progress is ignored. Neither the expected bit nor the sequence of reads changes.
- R9: done_o is a one-cycle pulse. Exactly one of pass_o and fail_o is high from done_o onward, and it holds until the next accepted start.
- R10: rd_vld_i is ignored while rd_req_o is low.
- R11: done_o, pass_o, fail_o and final_data_o update in the cycle after the rd_vld_i that concludes the operation, and rd_req_o is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin verifying an operation |
| erase_i | input | 1 | Operation is an erase (expected bit 7 is 1) |
| exp_data_i | input | DATA_W | Byte that was programmed |
| rd_req_o | output | 1 | Status read request, held until valid |
| rd_data_i | input | DATA_W | Status byte from the flash |
| rd_vld_i | input | 1 | rd_data_i holds the requested byte |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation verified good |
| fail_o | output | 1 | Operation failed or timed out |
| final_data_o | output | DATA_W | Byte from the concluding read |

## Verification
rd_req_o is due one cycle after an accepted start. Every result output is due one cycle after the rd_vld_i that concludes the operation. Each poll, recheck and confirm read costs one responder round trip, so the bench varies the responder latency and checks that the outcome does not depend on it. A behavioural model in the bench advances on each rising edge from the same inputs the design sees. Its predicted outputs are compared with the design on the following falling edge, so every comparison lands in the cycle where the registered result must already be present. Scenario checks after each done_o confirm the expected outcome and data byte for each path.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_POLL,
    PH_RECHK,
    PH_CONFIRM
  } phase_e;

  typedef struct packed {
    logic match;
    logic err_flag;
  } judge_t;
endpackage

// File: rtl/poll_rst_sync.sv
module poll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/poll_judge.sv
module poll_judge
  import poll_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STATUS_BIT = 7,
  parameter int ERR_BIT    = 5
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic              exp_bit_i,
  output judge_t            judge_o
);
  always_comb begin
    judge_o.match    = (byte_i[STATUS_BIT] == exp_bit_i);
    judge_o.err_flag = byte_i[ERR_BIT];
  end
endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int MAX_POLLS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);
  localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear_i | step_i;
    cnt_d  = clear_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == LAST_VAL);
endmodule

// File: rtl/poll_seq.sv
module poll_seq
  import poll_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   erase_i,
  input  logic   exp_bit_i,
  input  logic   rd_vld_i,
  input  judge_t judge_i,
  input  logic   last_i,
  output logic   rd_req_o,
  output logic   exp_bit_o,
  output logic   accept_o,
  output logic   bud_clr_o,
  output logic   bud_step_o,
  output logic   fin_o,
  output logic   fin_pass_o
);
  phase_e ph_q, ph_d;
  logic   exp_q, exp_d;

  always_comb begin
    ph_d       = ph_q;
    exp_d      = exp_q;
    accept_o   = 1'b0;
    bud_clr_o  = 1'b0;
    bud_step_o = 1'b0;
    fin_o      = 1'b0;
    fin_pass_o = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          accept_o  = 1'b1;
          bud_clr_o = 1'b1;
          exp_d     = erase_i ? 1'b1 : exp_bit_i;
          ph_d      = PH_POLL;
        end
      end
      PH_POLL: begin
        if (rd_vld_i) begin
          if (judge_i.match) begin
            ph_d = PH_CONFIRM;
          end else if (judge_i.err_flag) begin
            ph_d = PH_RECHK;
          end else if (last_i) begin
            fin_o = 1'b1;
            ph_d  = PH_IDLE;
          end else begin
            bud_step_o = 1'b1;
          end
        end
      end
      PH_RECHK: begin
        if (rd_vld_i) begin
          if (judge_i.match) begin
            ph_d = PH_CONFIRM;
          end else begin
            fin_o = 1'b1;
            ph_d  = PH_IDLE;
          end
        end
      end
      PH_CONFIRM: begin
        if (rd_vld_i) begin
          fin_o      = 1'b1;
          fin_pass_o = 1'b1;
          ph_d       = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      exp_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (accept_o) exp_q <= exp_d;
    end
  end

  assign rd_req_o  = (ph_q != PH_IDLE);
  assign exp_bit_o = exp_q;
endmodule

// File: rtl/poll_result.sv
module poll_result #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              fin_i,
  input  logic              fin_pass_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [DATA_W-1:0] data_o
);
  logic              done_q, pass_q, fail_q;
  logic              pass_d, fail_d, flag_en;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    flag_en = accept_i | fin_i;
    pass_d  = fin_i & fin_pass_i;
    fail_d  = fin_i & ~fin_pass_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= fin_i;
      if (flag_en) begin
        pass_q <= pass_d;
        fail_q <= fail_d;
      end
      if (fin_i) data_q <= byte_i;
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
  assign fail_o = fail_q;
  assign data_o = data_q;
endmodule

// File: rtl/flash_poll_verifier.sv
module flash_poll_verifier
  import poll_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STATUS_BIT = 7,
  parameter int ERR_BIT    = 5,
  parameter int MAX_POLLS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] exp_data_i,
  output logic              rd_req_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_vld_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [DATA_W-1:0] final_data_o
);
  logic   rst_int_n;
  logic   exp_bit, accept, bud_clr, bud_step, last, fin, fin_pass;
  judge_t judge;

  poll_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  poll_judge #(
    .DATA_W     (DATA_W),
    .STATUS_BIT (STATUS_BIT),
    .ERR_BIT    (ERR_BIT)
  ) u_judge (
    .byte_i    (rd_data_i),
    .exp_bit_i (exp_bit),
    .judge_o   (judge)
  );

  poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clear_i (bud_clr),
    .step_i  (bud_step),
    .last_o  (last)
  );

  poll_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .erase_i    (erase_i),
    .exp_bit_i  (exp_data_i[STATUS_BIT]),
    .rd_vld_i   (rd_vld_i),
    .judge_i    (judge),
    .last_i     (last),
    .rd_req_o   (rd_req_o),
    .exp_bit_o  (exp_bit),
    .accept_o   (accept),
    .bud_clr_o  (bud_clr),
    .bud_step_o (bud_step),
    .fin_o      (fin),
    .fin_pass_o (fin_pass)
  );

  poll_result #(.DATA_W(DATA_W)) u_result (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept_i   (accept),
    .fin_i      (fin),
    .fin_pass_i (fin_pass),
    .byte_i     (rd_data_i),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o),
    .data_o     (final_data_o)
  );
endmodule

// File: rtl/poll_checker.sv
module poll_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              rd_req_o,
  input logic              rd_vld_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o,
  input logic [DATA_W-1:0] final_data_o
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pass_o ^ fail_o));

  p_outcome_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));

  p_outcome_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_req_o && $past(!rd_req_o)) |-> ($stable(pass_o) && $stable(fail_o)));

  p_busy_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (!pass_o && !fail_o));

  p_start_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !rd_req_o) |=> rd_req_o);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_vld_i) |=> rd_req_o);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_req_o);

  p_done_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(rd_req_o) && $past(rd_vld_i)));

  p_final_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (final_data_o == $past(rd_data_i)));
endmodule

bind flash_poll_verifier poll_checker #(.DATA_W(DATA_W)) u_poll_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .rd_req_o     (rd_req_o),
  .rd_vld_i     (rd_vld_i),
  .rd_data_i    (rd_data_i),
  .done_o       (done_o),
  .pass_o       (pass_o),
  .fail_o       (fail_o),
  .final_data_o (final_data_o)
);

// File: tb/test_flash_poll_verifier.sv
module test_flash_poll_verifier;
  localparam int MAXP = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       erase_i = 1'b0;
  logic [7:0] exp_data_i = 8'h00;
  logic       rd_req_o;
  logic [7:0] rd_data_i = 8'h5A;
  logic       rd_vld_i = 1'b0;
  logic       done_o, pass_o, fail_o;
  logic [7:0] final_data_o;

  always #4 clk = ~clk;

  flash_poll_verifier #(.MAX_POLLS(MAXP)) i_flash_poll_verifier (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .erase_i      (erase_i),
    .exp_data_i   (exp_data_i),
    .rd_req_o     (rd_req_o),
    .rd_data_i    (rd_data_i),
    .rd_vld_i     (rd_vld_i),
    .done_o       (done_o),
    .pass_o       (pass_o),
    .fail_o       (fail_o),
    .final_data_o (final_data_o)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: step = 0 idle, 1 polling, 2 recheck, 3 confirm
  int         m_step;
  int         m_polls;
  bit         m_want;
  bit         m_done, m_pass, m_fail;
  logic [7:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_polls = 0; m_want = 0;
      m_done = 0; m_pass = 0; m_fail = 0; m_data = 8'h00;
    end else begin
      logic [7:0] b;
      bit hit;
      bit ended;
      bit good;
      m_done = 0;
      ended  = 0;
      good   = 0;
      b      = rd_data_i;
      hit    = (b[7] == m_want);
      if (m_step == 0) begin
        if (start_i) begin
          m_step = 1; m_polls = 0;
          m_want = erase_i ? 1'b1 : exp_data_i[7];   // R6
          m_pass = 0; m_fail = 0;                     // R2
        end
      end else if (rd_vld_i) begin                    // R10: vld counts only when busy
        if (m_step == 1) begin
          if (hit) m_step = 3;                        // R3
          else if (b[5]) m_step = 2;                  // R5
          else begin
            m_polls++;                                // R4
            if (m_polls >= MAXP) ended = 1;           // R7
          end
        end else if (m_step == 2) begin
          if (hit) m_step = 3; else ended = 1;
        end else begin
          ended = 1; good = 1;
        end
        if (ended) begin
          m_step = 0; m_done = 1; m_pass = good; m_fail = !good; m_data = b;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 rd_req_o", rd_req_o, m_step != 0);
      chk("R11 done_o", done_o, m_done);
      chk("R9 pass_o", pass_o, m_pass);
      chk("R9 fail_o", fail_o, m_fail);
      chk("R11 final_data_o", final_data_o, m_data);
    end
  end

  // Flash responder
  logic [7:0] resp_q[$];
  int         lat = 0;
  int         wcnt = 0;
  bit         stray = 1'b0;

  always @(negedge clk) begin
    if (stray) begin
      rd_vld_i  = 1'b1;
      rd_data_i = 8'hFF;
      stray     = 1'b0;
    end else if (rd_req_o && resp_q.size() > 0 && wcnt >= lat) begin
      rd_vld_i  = 1'b1;
      rd_data_i = resp_q.pop_front();
      wcnt      = 0;
    end else begin
      rd_vld_i  = 1'b0;
      rd_data_i = 8'h5A;
      if (rd_req_o) wcnt++;
    end
  end

  task automatic op(bit er, logic [7:0] ex, int l, bit busy_start);
    int w;
    @(negedge clk);
    lat = l; erase_i = er; exp_data_i = ex; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; erase_i = 1'b0; exp_data_i = ~ex;
    if (busy_start) begin
      @(negedge clk);
      start_i = 1'b1; erase_i = 1'b1; exp_data_i = 8'hFF;
      @(negedge clk);
      start_i = 1'b0; erase_i = 1'b0;
    end
    w = 0;
    while (!done_o && w < 400) begin
      @(negedge clk);
      w++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rd_req_o", rd_req_o, 0);
    chk("R1 done_o", done_o, 0);
    chk("R1 pass_o", pass_o, 0);
    chk("R1 fail_o", fail_o, 0);
    chk("R1 final_data_o", final_data_o, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 + R3: two plain polls, match, confirm byte reported
    resp_q = '{8'h05, 8'h05, 8'h85, 8'hA5};
    op(1'b0, 8'hA5, 2, 1'b0);
    chk("R3 pass_o", pass_o, 1);
    chk("R3 final_data_o", final_data_o, 8'hA5);
    chk("R4 queue drained", resp_q.size(), 0);
    repeat (3) @(negedge clk);
    chk("R9 pass held", pass_o, 1);
    chk("R9 done pulse", done_o, 0);

    // R10: stray valid while idle changes nothing
    stray = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 pass_o", pass_o, 1);
    chk("R10 final_data_o", final_data_o, 8'hA5);
    chk("R10 rd_req_o", rd_req_o, 0);

    // R5: error flag then recheck match, confirm
    resp_q = '{8'hBC, 8'h3C, 8'h3C};
    op(1'b0, 8'h3C, 0, 1'b0);
    chk("R5 pass after recheck", pass_o, 1);
    chk("R5 final_data_o", final_data_o, 8'h3C);

    // R5: recheck mismatch fails
    resp_q = '{8'hA0, 8'hA1};
    op(1'b0, 8'h00, 1, 1'b0);
    chk("R5 fail_o", fail_o, 1);
    chk("R5 final_data_o", final_data_o, 8'hA1);

    // R6: erase expects bit 7 = 1 despite exp_data 0
    resp_q = '{8'h00, 8'h80, 8'hFF};
    op(1'b1, 8'h00, 3, 1'b0);
    chk("R6 pass_o", pass_o, 1);
    chk("R6 final_data_o", final_data_o, 8'hFF);

    // R7: budget exhausted
    for (int i = 0; i < MAXP; i++) resp_q.push_back(8'h00);
    resp_q.push_back(8'h80);
    op(1'b0, 8'h80, 0, 1'b0);
    chk("R7 fail_o", fail_o, 1);
    chk("R7 final_data_o", final_data_o, 8'h00);
    chk("R7 unread bytes", resp_q.size(), 1);
    resp_q.delete();

    // R8: busy start with erase ignored
    resp_q = '{8'h02, 8'h12};
    op(1'b0, 8'h12, 4, 1'b1);
    chk("R8 pass_o", pass_o, 1);
    chk("R8 final_data_o", final_data_o, 8'h12);
    repeat (3) @(negedge clk);
    chk("R8 no restart", rd_req_o, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule